// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the handler entry for an 8-bit processor core. It sees four kinds of entry request: a reset request, a non-maskable interrupt, a maskable interrupt and a software break that the instruction decoder raises after it has fetched the break opcode. When idle, it picks the most urgent request and takes a snapshot of the program counter, stack pointer and status byte supplied by the core. It then runs a fixed sequence of bus cycles on a simple synchronous memory port: idle preparation cycles, three stack cycles and two vector reads.

The three stack cycles push the return address and status. On a reset entry they only step the stack pointer down. The two vector reads are little-endian and return the handler address. At the end the block presents the new program counter, the new stack pointer and the set interrupt-disable flag, and raises a one-cycle completion pulse. The core holds itself stalled until that pulse.

The bus returns read data combinationally in the same cycle the address is presented. A non-maskable request is held in a pending latch, so a one-cycle pulse is never lost, even while another entry is in progress.

Top module: `irq_entry_seq`

## Requirements
- R1: The handler address is read low byte first, then high byte, from 0xFFFA/0xFFFB for the non-maskable interrupt, 0xFFFC/0xFFFD for reset, and 0xFFFE/0xFFFF for both the maskable interrupt and break. `pc_o` becomes {high, low}, and vector addresses are never written.
- R2: A non-reset entry writes three bytes in this order: PC[15:8] to 0x0100+S, then PC[7:0] to 0x0100+S-1, then the status byte to 0x0100+S-2, with 8-bit wrap of S. `sp_o` becomes S-3 modulo 256.
- R3: `bus_we_o` is high only during the three push cycles, and only with an address in page 0x01.
- R4: The pushed status equals `status_i` except bit 4. Bit 4 is 1 for a break and 0 for the non-maskable and maskable interrupts.
- R5: A reset entry performs no writes. It still presents three stack-page addresses 0x0100+S, S-1, S-2 with `bus_we_o` low, and `sp_o` becomes S-3 modulo 256.
- R6: `iflag_o` is 1 once any entry completes.
- R7: Requests are chosen in priority order: reset request, pending non-maskable, maskable, break. The maskable request is ignored while `status_i` bit 2 (interrupt disable) is 1.
- R8: A one-cycle `nmi_i` pulse is latched, including while another entry runs, and is serviced once that entry ends. The latch clears when its own entry completes, so one pulse yields exactly one entry.
- R9: For reset, maskable and break requests, `done_o` is a one-cycle pulse after clock edge 8 (edge 7 for break), counting the accepting edge as edge 1. A non-maskable pulse is accepted one edge after the edge that latches it.
- R10: Synchronous reset `rst` clears `pc_o`, `sp_o`, `iflag_o`, `done_o`, any entry in progress and any pending non-maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_req_i | input | 1 | Reset entry request (level) |
| nmi_i | input | 1 | Non-maskable request (pulse, latched) |
| irq_i | input | 1 | Maskable request (level) |
| brk_i | input | 1 | Software break entry request, sampled when idle |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 8 | Current stack pointer |
| status_i | input | 8 | Current status byte, bit 2 interrupt disable |
| bus_addr_o | output | 16 | Memory address |
| bus_wdata_o | output | 8 | Memory write data |
| bus_we_o | output | 1 | Memory write enable |
| bus_rdata_i | input | 8 | Memory read data, valid in the address cycle |
| pc_o | output | 16 | Handler address loaded at completion |
| sp_o | output | 8 | Stack pointer after entry |
| iflag_o | output | 1 | Interrupt-disable flag after entry |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a request on a falling edge and counts rising edges until `done_o` appears. That count must be exactly 8 for reset and maskable entries, 7 for break and 9 for a non-maskable pulse. The completion values are read at the falling edge after the pulse. Stack traffic is logged on every falling edge, away from the edge where the registers change, and is compared with addresses and bytes computed from the snapshot inputs. For the priority and latching cases, one entry runs straight into the next, so the second count starts at the first pulse. Windows of several idle cycles with no pulse and no write check that masked or cleared requests do nothing.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PUSH_BYTES = 3;
    localparam int BFLAG_BIT  = 4;
    localparam int IFLAG_BIT  = 2;

    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_MASK   = 16'hFFFE;

    typedef enum logic [1:0] {
        K_RST = 2'd0,
        K_NMI = 2'd1,
        K_IRQ = 2'd2,
        K_BRK = 2'd3
    } entry_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_STACK,
        ST_VLO,
        ST_VHI
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] status;
        entry_kind_t       kind;
    } entry_snap_t;

    function automatic logic [ADDR_W-1:0] vector_addr(entry_kind_t k);
        logic [ADDR_W-1:0] v;
        case (k)
            K_NMI:   v = VEC_NMI;
            K_RST:   v = VEC_RST;
            default: v = VEC_MASK;
        endcase
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] stacked_status(logic [DATA_W-1:0] s,
                                                         entry_kind_t k);
        logic [DATA_W-1:0] r;
        r = s;
        r[BFLAG_BIT] = (k == K_BRK);
        return r;
    endfunction

endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
    import irq_entry_pkg::*;
(
    input  logic        rst_req,
    input  logic        nmi_pend,
    input  logic        irq_req,
    input  logic        brk_req,
    input  logic        irq_masked,
    output logic        req_valid,
    output entry_kind_t req_kind
);

    always_comb begin
        req_valid = 1'b1;
        req_kind  = K_RST;
        if (rst_req) begin
            req_kind = K_RST;
        end else if (nmi_pend) begin
            req_kind = K_NMI;
        end else if (irq_req && !irq_masked) begin
            req_kind = K_IRQ;
        end else if (brk_req) begin
            req_kind = K_BRK;
        end else begin
            req_valid = 1'b0;
        end
    end

endmodule

// File: rtl/irq_entry_nmi_latch.sv
module irq_entry_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic clr,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (nmi_in) begin
            pend <= 1'b1;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_entry_pkg::*;
#(
    parameter int PREP_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  entry_kind_t         req_kind,
    input  logic [ADDR_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]   sp_in,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [DATA_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   wdata,
    output logic                we,
    output logic [ADDR_W-1:0]   pc_out,
    output logic [DATA_W-1:0]   sp_out,
    output logic                iflag_out,
    output logic                done,
    output logic                nmi_clr
);

    localparam int CNT_MAX = (PREP_CYC > PUSH_BYTES) ? PREP_CYC : PUSH_BYTES;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PREP_FULL  = CW'(PREP_CYC - 1);
    localparam logic [CW-1:0] PREP_SHORT = CW'(PREP_CYC - 2);
    localparam logic [CW-1:0] PUSH_LAST  = CW'(PUSH_BYTES - 1);

    seq_state_t        state;
    logic [CW-1:0]     cnt;
    entry_snap_t       snap;
    logic [DATA_W-1:0] vec_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            snap      <= '0;
            vec_lo    <= '0;
            pc_out    <= '0;
            sp_out    <= '0;
            iflag_out <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        snap.pc     <= pc_in;
                        snap.sp     <= sp_in;
                        snap.status <= status_in;
                        snap.kind   <= req_kind;
                        cnt         <= (req_kind == K_BRK) ? PREP_SHORT : PREP_FULL;
                        state       <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (cnt == '0) begin
                        state <= ST_STACK;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STACK: begin
                    snap.sp <= snap.sp - 1'b1;
                    if (cnt == PUSH_LAST) begin
                        cnt   <= '0;
                        state <= ST_VLO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_VLO: begin
                    vec_lo <= rdata;
                    state  <= ST_VHI;
                end
                ST_VHI: begin
                    pc_out    <= {rdata, vec_lo};
                    sp_out    <= snap.sp;
                    iflag_out <= 1'b1;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        addr  = '0;
        wdata = '0;
        we    = 1'b0;
        case (state)
            ST_STACK: begin
                addr = {STACK_PAGE, snap.sp};
                we   = (snap.kind != K_RST);
                if (cnt == '0) begin
                    wdata = snap.pc[ADDR_W-1:DATA_W];
                end else if (cnt == CW'(1)) begin
                    wdata = snap.pc[DATA_W-1:0];
                end else begin
                    wdata = stacked_status(snap.status, snap.kind);
                end
            end
            ST_VLO:  addr = vector_addr(snap.kind);
            ST_VHI:  addr = vector_addr(snap.kind) | ADDR_W'(1);
            default: ;
        endcase
    end

    assign nmi_clr = (state == ST_VHI) && (snap.kind == K_NMI);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int PREP_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rst_req_i,
    input  logic        nmi_i,
    input  logic        irq_i,
    input  logic        brk_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  sp_i,
    input  logic [7:0]  status_i,
    output logic [15:0] bus_addr_o,
    output logic [7:0]  bus_wdata_o,
    output logic        bus_we_o,
    input  logic [7:0]  bus_rdata_i,
    output logic [15:0] pc_o,
    output logic [7:0]  sp_o,
    output logic        iflag_o,
    output logic        done_o
);

    logic        nmi_pend;
    logic        nmi_clr;
    logic        req_valid;
    entry_kind_t req_kind;

    irq_entry_nmi_latch u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_in (nmi_i),
        .clr    (nmi_clr),
        .pend   (nmi_pend)
    );

    irq_entry_arb u_arb (
        .rst_req    (rst_req_i),
        .nmi_pend   (nmi_pend),
        .irq_req    (irq_i),
        .brk_req    (brk_i),
        .irq_masked (status_i[IFLAG_BIT]),
        .req_valid  (req_valid),
        .req_kind   (req_kind)
    );

    irq_entry_ctl #(.PREP_CYC(PREP_CYC)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .pc_in     (pc_i),
        .sp_in     (sp_i),
        .status_in (status_i),
        .rdata     (bus_rdata_i),
        .addr      (bus_addr_o),
        .wdata     (bus_wdata_o),
        .we        (bus_we_o),
        .pc_out    (pc_o),
        .sp_out    (sp_o),
        .iflag_out (iflag_o),
        .done      (done_o),
        .nmi_clr   (nmi_clr)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr_o,
    input logic        bus_we_o,
    input logic        done_o,
    input logic        iflag_o
);

    AST_WE_IN_STACK: assert property (@(posedge clk) disable iff (rst)
        bus_we_o |-> (bus_addr_o[15:8] == 8'h01)); // R3

    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (rst)
        (bus_we_o && $past(bus_we_o)) |-> (bus_addr_o[7:0] == $past(bus_addr_o[7:0]) - 8'd1)); // R2

    AST_VEC_READONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_o[15:4] == 12'hFFF) |-> !bus_we_o); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_IFLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> iflag_o); // R6

    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !bus_we_o); // R3

endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr_o (bus_addr_o),
    .bus_we_o   (bus_we_o),
    .done_o     (done_o),
    .iflag_o    (iflag_o)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_req_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic        irq_i = 1'b0;
    logic        brk_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  sp_i = '0;
    logic [7:0]  status_i = '0;
    logic [15:0] bus_addr_o;
    logic [7:0]  bus_wdata_o;
    logic        bus_we_o;
    logic [7:0]  bus_rdata_i;
    logic [15:0] pc_o;
    logic [7:0]  sp_o;
    logic        iflag_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [15:0] wr_addr [8];
    logic [7:0]  wr_data [8];
    int          wr_cnt = 0;
    logic [15:0] dm_addr [8];
    int          dm_cnt = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return {a[3:0], ~a[3:0]};
    endfunction

    assign bus_rdata_i = memf(bus_addr_o);

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_i(nmi_i), .irq_i(irq_i),
        .brk_i(brk_i), .pc_i(pc_i), .sp_i(sp_i), .status_i(status_i),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_we_o(bus_we_o),
        .bus_rdata_i(bus_rdata_i), .pc_o(pc_o), .sp_o(sp_o), .iflag_o(iflag_o),
        .done_o(done_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_we_o) begin
                if (wr_cnt < 8) begin
                    wr_addr[wr_cnt] = bus_addr_o;
                    wr_data[wr_cnt] = bus_wdata_o;
                end
                wr_cnt = wr_cnt + 1;
            end else if (bus_addr_o[15:8] == 8'h01) begin
                if (dm_cnt < 8) dm_addr[dm_cnt] = bus_addr_o;
                dm_cnt = dm_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        wr_cnt = 0;
        dm_cnt = 0;
    endtask

    task automatic drop_reqs();
        rst_req_i = 1'b0; irq_i = 1'b0; brk_i = 1'b0; nmi_i = 1'b0;
    endtask

    // counts rising edges until done_o is seen at a falling edge
    task automatic wait_done(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1) drop_reqs();
            if (done_o) break;
        end
    endtask

    // kind: 0 reset, 1 nmi, 2 irq, 3 break
    task automatic check_entry(input int k, input logic [15:0] pc, input logic [7:0] sp,
                               input logic [7:0] st, input int n, input int exp_n);
        logic [15:0] v;
        logic [15:0] exp_pc;
        logic [7:0]  exp_st;
        v = (k == 1) ? 16'hFFFA : (k == 0) ? 16'hFFFC : 16'hFFFE;
        exp_pc = {memf(v + 16'd1), memf(v)};
        exp_st = st;
        exp_st[4] = (k == 3);
        chk(n == exp_n, "R9", "edges to done", n, exp_n);
        chk(done_o == 1'b1, "R9", "done seen", {31'd0, done_o}, 1);
        chk(pc_o == exp_pc, "R1", "vector pc", pc_o, exp_pc);
        chk(sp_o == sp - 8'd3, k == 0 ? "R5" : "R2", "sp after", sp_o, sp - 8'd3);
        chk(iflag_o == 1'b1, "R6", "iflag", {31'd0, iflag_o}, 1);
        if (k == 0) begin
            chk(wr_cnt == 0, "R5", "reset writes", wr_cnt, 0);
            chk(dm_cnt == 3, "R5", "dummy cycles", dm_cnt, 3);
            for (int i = 0; i < 3; i++)
                if (i < dm_cnt)
                    chk(dm_addr[i] == {8'h01, sp - 8'(i)}, "R5", "dummy addr",
                        dm_addr[i], {8'h01, sp - 8'(i)});
        end else begin
            chk(wr_cnt == 3, "R3", "write count", wr_cnt, 3);
            chk(dm_cnt == 0, "R3", "no stack idle", dm_cnt, 0);
            for (int i = 0; i < 3; i++)
                if (i < wr_cnt)
                    chk(wr_addr[i] == {8'h01, sp - 8'(i)}, "R2", "push addr",
                        wr_addr[i], {8'h01, sp - 8'(i)});
            if (wr_cnt >= 3) begin
                chk(wr_data[0] == pc[15:8], "R2", "push pc hi", wr_data[0], pc[15:8]);
                chk(wr_data[1] == pc[7:0], "R2", "push pc lo", wr_data[1], pc[7:0]);
                chk(wr_data[2] == exp_st, "R4", "push status", wr_data[2], exp_st);
            end
        end
    endtask

    task automatic run_entry(input int k, input logic [15:0] pc, input logic [7:0] sp,
                             input logic [7:0] st);
        int n;
        @(negedge clk);
        clear_log();
        pc_i = pc; sp_i = sp; status_i = st;
        case (k)
            0: rst_req_i = 1'b1;
            1: nmi_i = 1'b1;
            2: irq_i = 1'b1;
            default: brk_i = 1'b1;
        endcase
        wait_done(20, n);
        check_entry(k, pc, sp, st, n, (k == 3) ? 7 : (k == 1) ? 9 : 8);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int seen;
        seen = 0;
        clear_log();
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 0) drop_reqs();
            if (done_o) seen++;
        end
        chk(seen == 0, req, "no entry", seen, 0);
        chk(wr_cnt == 0, req, "no writes", wr_cnt, 0);
    endtask

    initial begin
        logic [7:0] sps [4];
        logic [7:0] sts [3];
        int n;
        sps = '{8'h00, 8'h02, 8'h80, 8'hFF};
        sts = '{8'h00, 8'hDB, 8'h3A};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(pc_o == 16'h0, "R10", "pc reset", pc_o, 0);
        chk(sp_o == 8'h0, "R10", "sp reset", sp_o, 0);
        chk(iflag_o == 1'b0, "R10", "iflag reset", {31'd0, iflag_o}, 0);
        chk(done_o == 1'b0, "R10", "done reset", {31'd0, done_o}, 0);
        chk(bus_we_o == 1'b0, "R10", "we reset", {31'd0, bus_we_o}, 0);
        rst = 1'b0;

        // sweep of kinds, stack pointers and status bytes (R1 R2 R4 R5)
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 4; s++)
                for (int t = 0; t < 3; t++) begin
                    logic [7:0] st;
                    st = (k == 2) ? (sts[t] & 8'hFB) : (sts[t] | 8'h04);
                    run_entry(k, 16'h1234 + 16'(k * 257 + s * 16 + t), sps[s], st);
                end

        // R7: all requests together -> reset first, then latched NMI (R8)
        @(negedge clk);
        clear_log();
        pc_i = 16'hBEEF; sp_i = 8'h40; status_i = 8'h00;
        rst_req_i = 1'b1; nmi_i = 1'b1; irq_i = 1'b1; brk_i = 1'b1;
        wait_done(20, n);
        check_entry(0, 16'hBEEF, 8'h40, 8'h00, n, 8);
        clear_log();
        wait_done(20, n);
        check_entry(1, 16'hBEEF, 8'h40, 8'h00, n, 8); // R8 serviced after
        expect_quiet(12, "R8");

        // R7: maskable beats break when enabled
        @(negedge clk);
        clear_log();
        pc_i = 16'h4321; sp_i = 8'h10; status_i = 8'h91;
        irq_i = 1'b1; brk_i = 1'b1;
        wait_done(20, n);
        check_entry(2, 16'h4321, 8'h10, 8'h91, n, 8);

        // R7: masked maskable request loses to break
        @(negedge clk);
        clear_log();
        pc_i = 16'h0A0B; sp_i = 8'h33; status_i = 8'h04;
        irq_i = 1'b1; brk_i = 1'b1;
        wait_done(20, n);
        check_entry(3, 16'h0A0B, 8'h33, 8'h04, n, 7);

        // R7: masked maskable request alone is ignored
        @(negedge clk);
        status_i = 8'h04; irq_i = 1'b1;
        expect_quiet(12, "R7");

        // R8: NMI pulse during a maskable entry is serviced afterwards
        @(negedge clk);
        clear_log();
        pc_i = 16'h7777; sp_i = 8'hF0; status_i = 8'h00; irq_i = 1'b1;
        @(posedge clk); @(negedge clk); irq_i = 1'b0;
        @(posedge clk); @(negedge clk); nmi_i = 1'b1;
        @(posedge clk); @(negedge clk); nmi_i = 1'b0;
        wait_done(20, n);
        check_entry(2, 16'h7777, 8'hF0, 8'h00, n + 3, 8);
        clear_log();
        wait_done(20, n);
        check_entry(1, 16'h7777, 8'hF0, 8'h00, n, 8);
        expect_quiet(12, "R8");

        // R10: reset mid-entry clears progress and pending NMI
        @(negedge clk);
        irq_i = 1'b1; status_i = 8'h00;
        @(posedge clk); @(negedge clk); irq_i = 1'b0; nmi_i = 1'b1;
        @(posedge clk); @(negedge clk); nmi_i = 1'b0; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk(pc_o == 16'h0, "R10", "pc after rst", pc_o, 0);
        chk(iflag_o == 1'b0, "R10", "iflag after rst", {31'd0, iflag_o}, 0);
        rst = 1'b0;
        expect_quiet(12, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule